// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

A 32-pin general-purpose I/O port controlled through a small register file. Software sets an output value and a per-pin output enable, and reads back the synchronized level of every pad. Each pin can also raise an interrupt. A 2-bit trigger code selects low level, high level, rising edge or falling edge. A separate per-pin select bit makes the pin trigger on any transition instead.

Detected conditions set sticky status bits. Software clears a bit by writing 1 to it. The status is ANDed with a mask and ORed into two lines: one for the lower half of the pins and one for the upper half. Pad inputs go through a two-stage synchronizer before detection. An edge is found by comparing the synchronized value with its value one cycle earlier.

The register bus is a plain synchronous port with no flow control. It is always ready. A write takes effect on the clock edge where `reg_wr_en` is high. Read data is combinational from `reg_addr`. `reg_addr` is a word index, and byte offset 4·k corresponds to index k:

| Index | Register |
|-------|----------|
| 0 | output data |
| 1 | direction |
| 2 | pad status |
| 3 | trigger configuration, lower half |
| 4 | trigger configuration, upper half |
| 5 | mask |
| 6 | status |
| 7 | any-edge select |

Top module: `gpio_irq_port`

## Requirements
- R1: A clock edge with `rst_n` low clears data, direction, both trigger registers, mask, any-edge select and status to zero. Both interrupt lines are then low.
- R2: `pad_out` equals the data register (index 0) and `pad_oe` equals the direction register (index 1). A direction bit of 1 enables the pin's output driver. Both registers read back what was written.
- R3: The pad status register (index 2) returns `pad_in` two clock edges after it changes, for every pin and whatever its direction. Writes to it have no effect.
- R4: Pin n's 2-bit trigger code sits at bits 2·(n mod 16)+1:2·(n mod 16). It is in the register at index 3 for n < 16 and in the register at index 4 for n ≥ 16. Code 00 = low level and code 01 = high level. A level code sets the status bit in every cycle that the level holds.
- R5: Code 10 = rising edge and code 11 = falling edge. Each qualifying transition sets the status bit once. A steady level or the opposite transition does not set it.
- R6: When a pin's bit in the any-edge select register (index 7) is 1, every transition of that pin sets its status bit and its trigger code has no effect.
- R7: Writing the status register (index 6) clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R8: When a detected condition and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: Status bits are set regardless of the mask (index 5). A status bit whose mask bit is 0 does not drive an interrupt line.
- R10: `irq_lo` is high when any pin 0–15 has both status and mask set. `irq_hi` does the same for pins 16–31.
- R11: A status bit becomes visible on the third clock edge after the pad change that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq_lo | output | 1 | Interrupt line for pins 0–15 |
| irq_hi | output | 1 | Interrupt line for pins 16–31 |

## Verification
The hardest case to create is a clearing write that lands in the same cycle as a detection, because edge events last only one cycle. The stimulus reaches it with a level trigger: the pad is held at the active level, which makes the condition true on every cycle, and the clear is written while it holds. The status must still read 1 afterwards.

The cycle-exact latency through the synchronizer is probed by sampling the status just before and just after the third edge that follows a pad change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_PAD    = 3'd2,
    REG_CFG_LO = 3'd3,
    REG_CFG_HI = 3'd4,
    REG_MASK   = 3'd5,
    REG_STAT   = 3'd6,
    REG_ANY    = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   pin_sync,
  input  logic [2*N-1:0] trig_cfg,
  input  logic [N-1:0]   any_sel,
  output logic [N-1:0]   evt
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  generate
    for (genvar p = 0; p < N; p++) begin : g_pin
      trig_e code;
      logic  rise, fall;
      assign code = trig_e'(trig_cfg[2*p +: 2]);
      assign rise = pin_sync[p] & ~prev_q[p];
      assign fall = ~pin_sync[p] & prev_q[p];
      always_comb begin
        if (any_sel[p]) begin
          evt[p] = rise | fall;
        end else begin
          case (code)
            TRIG_LOW:  evt[p] = ~pin_sync[p];
            TRIG_HIGH: evt[p] = pin_sync[p];
            TRIG_RISE: evt[p] = rise;
            default:   evt[p] = fall;
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int N      = 32,
  parameter int NGROUP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      evt,
  input  logic              clr_en,
  input  logic [N-1:0]      clr_bits,
  input  logic [N-1:0]      mask,
  output logic [N-1:0]      stat,
  output logic [NGROUP-1:0] irq_grp
);
  localparam int GW = N / NGROUP;

  logic [N-1:0] clr_vec;
  assign clr_vec = clr_en ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_vec) | evt;
  end

  generate
    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
      assign irq_grp[g] = |(stat[g*GW +: GW] & mask[g*GW +: GW]);
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int N_PINS      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [N_PINS-1:0]    reg_wdata,
  output logic [N_PINS-1:0]    reg_rdata,
  input  logic [N_PINS-1:0]    pad_in,
  output logic [N_PINS-1:0]    pad_out,
  output logic [N_PINS-1:0]    pad_oe,
  output logic                 irq_lo,
  output logic                 irq_hi
);
  localparam int HALF = N_PINS / 2;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  logic [N_PINS-1:0] data_q, dir_q, mask_q, any_q, cfg_lo_q, cfg_hi_q;
  logic [N_PINS-1:0] pin_sync, pin_evt, irq_stat;
  logic [1:0]        irq_grp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      mask_q   <= '0;
      any_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
    end else if (reg_wr_en) begin
      case (sel)
        REG_DATA:   data_q   <= reg_wdata;
        REG_DIR:    dir_q    <= reg_wdata;
        REG_CFG_LO: cfg_lo_q <= reg_wdata;
        REG_CFG_HI: cfg_hi_q <= reg_wdata;
        REG_MASK:   mask_q   <= reg_wdata;
        REG_ANY:    any_q    <= reg_wdata;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_trig_detect #(.N(N_PINS)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin_sync),
    .trig_cfg ({cfg_hi_q[2*HALF-1:0], cfg_lo_q[2*HALF-1:0]}),
    .any_sel  (any_q),
    .evt      (pin_evt)
  );

  gpio_irq_status #(.N(N_PINS), .NGROUP(2)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (pin_evt),
    .clr_en   (reg_wr_en && (sel == REG_STAT)),
    .clr_bits (reg_wdata),
    .mask     (mask_q),
    .stat     (irq_stat),
    .irq_grp  (irq_grp)
  );

  always_comb begin
    case (sel)
      REG_DATA:   reg_rdata = data_q;
      REG_DIR:    reg_rdata = dir_q;
      REG_PAD:    reg_rdata = pin_sync;
      REG_CFG_LO: reg_rdata = cfg_lo_q;
      REG_CFG_HI: reg_rdata = cfg_hi_q;
      REG_MASK:   reg_rdata = mask_q;
      REG_STAT:   reg_rdata = irq_stat;
      default:    reg_rdata = any_q;
    endcase
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign irq_lo  = irq_grp[0];
  assign irq_hi  = irq_grp[1];
endmodule

// File: rtl/gpio_irq_port_checker.sv
module gpio_irq_port_checker
  import gpio_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr_en,
  input logic [REG_IDX_W-1:0] reg_addr,
  input logic [N_PINS-1:0]    reg_wdata,
  input logic [N_PINS-1:0]    pad_out,
  input logic [N_PINS-1:0]    pad_oe,
  input logic                 irq_lo,
  input logic                 irq_hi,
  input logic [N_PINS-1:0]    stat,
  input logic [N_PINS-1:0]    evt,
  input logic [N_PINS-1:0]    mask
);
  localparam int HALF = N_PINS / 2;

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (pad_out == '0 && pad_oe == '0 && !irq_lo && !irq_hi));

  p_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == REG_DIR) |=> pad_oe == $past(reg_wdata));

  p_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == REG_DATA) |=> pad_out == $past(reg_wdata));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == REG_STAT) |=> ((stat & $past(reg_wdata & ~evt)) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));

  p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (!irq_lo && !irq_hi));

  p_lo_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (|mask[HALF-1:0]));

  p_hi_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (|mask[N_PINS-1:HALF]));
endmodule

bind gpio_irq_port gpio_irq_port_checker #(.N_PINS(N_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi),
  .stat      (irq_stat),
  .evt       (pin_evt),
  .mask      (mask_q)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_DATA = 3'd0, A_DIR = 3'd1, A_PAD = 3'd2, A_CLO = 3'd3,
                         A_CHI = 3'd4, A_MASK = 3'd5, A_STAT = 3'd6, A_ANY = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] cfg_lo = '0, cfg_hi = '0, pads = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    peek(a, v);
  endtask

  task automatic set_pads(input logic [31:0] v);
    @(negedge clk);
    pads = v; pad_in = v;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] put_code(input logic [31:0] base, input int pin, input logic [1:0] code);
    logic [31:0] r = base;
    r[2*(pin % 16) +: 2] = code;
    return r;
  endfunction

  task automatic set_code(input int pin, input logic [1:0] code);
    if (pin < 16) begin cfg_lo = put_code(cfg_lo, pin, code); wr(A_CLO, cfg_lo); end
    else          begin cfg_hi = put_code(cfg_hi, pin, code); wr(A_CHI, cfg_hi); end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(A_DATA, v); chk("R1 data", v, 0);
    rd(A_DIR, v);  chk("R1 dir", v, 0);
    rd(A_CLO, v);  chk("R1 cfg lo", v, 0);
    rd(A_CHI, v);  chk("R1 cfg hi", v, 0);
    rd(A_MASK, v); chk("R1 mask", v, 0);
    rd(A_ANY, v);  chk("R1 any", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 irq", {30'd0, irq_hi, irq_lo}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_outputs();
    logic [31:0] v;
    wr(A_DATA, 32'hA5A5_0F0F);
    wr(A_DIR, 32'hFFFF_0000);
    chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(A_DATA, v); chk("R2 data rb", v, 32'hA5A5_0F0F);
    rd(A_DIR, v);  chk("R2 dir rb", v, 32'hFFFF_0000);
  endtask

  task automatic t_pad_status();
    logic [31:0] v;
    @(negedge clk); pad_in = 32'h1234_5678;
    @(negedge clk); peek(A_PAD, v); chk("R3 one edge old", v, 32'h0);
    @(negedge clk); peek(A_PAD, v); chk("R3 two edges", v, 32'h1234_5678);
    wr(A_PAD, 32'hFFFF_FFFF);
    rd(A_PAD, v); chk("R3 write ignored", v, 32'h1234_5678);
    cfg_lo = 32'h5555_5555; cfg_hi = 32'h5555_5555;
    wr(A_CLO, cfg_lo); wr(A_CHI, cfg_hi);
    set_pads(0);
    @(negedge clk);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R7 all cleared", v, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    set_pads(32'h8);
    rd(A_STAT, v); chk("R4 high level pin3", v, 32'h8);
    chk("R9 masked no irq", {31'd0, irq_lo}, 0);
    wr(A_MASK, 32'h8);
    chk("R10 irq_lo", {30'd0, irq_hi, irq_lo}, 2'b01);
    wr(A_STAT, 32'h8);
    rd(A_STAT, v); chk("R8 set wins over clear", v, 32'h8);
    set_pads(0);
    wr(A_STAT, 32'h8);
    rd(A_STAT, v); chk("R7 cleared pin3", v, 0);
    chk("R10 irq_lo low", {31'd0, irq_lo}, 0);
    set_code(20, 2'b00);
    rd(A_STAT, v); chk("R4 low level pin20", v, 32'h0010_0000);
    wr(A_MASK, 32'h0010_0000);
    chk("R10 irq_hi", {30'd0, irq_hi, irq_lo}, 2'b10);
    set_code(20, 2'b01);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_MASK, 0);
    rd(A_STAT, v); chk("R4 pin20 quiet", v, 0);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    set_code(5, 2'b10);
    set_pads(32'h20);
    rd(A_STAT, v); chk("R5 rising pin5", v, 32'h20);
    wr(A_STAT, 32'h20);
    rd(A_STAT, v); chk("R5 rise once", v, 0);
    set_pads(0);
    rd(A_STAT, v); chk("R5 fall ignored on rise code", v, 0);
    set_code(17, 2'b11);
    set_pads(32'h0002_0000);
    rd(A_STAT, v); chk("R5 rise ignored on fall code", v, 0);
    set_pads(0);
    rd(A_STAT, v); chk("R5 falling pin17", v, 32'h0002_0000);
    wr(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 32'h20;
    @(negedge clk); @(negedge clk);
    peek(A_STAT, v); chk("R11 not yet after two edges", v, 0);
    @(negedge clk);
    peek(A_STAT, v); chk("R11 set on third edge", v, 32'h20);
    set_pads(0);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_any_edge();
    logic [31:0] v;
    set_code(9, 2'b00);
    wr(A_ANY, 32'h200);
    wr(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(A_STAT, v); chk("R6 level code ignored", v, 0);
    set_pads(32'h200);
    rd(A_STAT, v); chk("R6 rise flagged", v, 32'h200);
    wr(A_STAT, 32'h200);
    set_pads(0);
    rd(A_STAT, v); chk("R6 fall flagged", v, 32'h200);
    wr(A_STAT, 32'h200);
    set_pads(32'h220);
    rd(A_STAT, v); chk("R7 two pins set", v, 32'h220);
    wr(A_STAT, 32'h200);
    rd(A_STAT, v); chk("R7 zero bits kept", v, 32'h20);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_outputs();
    t_pad_status();
    t_level();
    t_edges();
    t_any_edge();
    finish_run();
  end
endmodule